// File: doc/BRIEF.md
# Linear Page Table Miss Walker

This block sits beside a small fully associative translation look-aside buffer and resolves misses in hardware. A request presents a virtual page number. If the buffer holds it, the frame number is returned at once. If not, the block works out where that page's table entry lives. The table is one flat array of 8-byte entries placed in the highest part of the virtual space. The block then looks up that entry's own virtual page in the same buffer, reads the entry from memory at the resulting physical address, and writes the new mapping into the buffer.

When the page that holds the needed table entry has no mapping, the block does not walk any tree. It reports a fault so that software can do the full walk and load mappings through the insert port. A fetched entry marked invalid gives a page fault with a different cause.

Software inserts and hardware refills go through one write path. Software wins a collision, and the refill is retried on the next cycle. A write to a page number already resident overwrites that entry in place. Any other write takes the slot named by a round-robin pointer.

Top module: `vlpt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req are 0, and the buffer is empty, so any request before an insert gives a nested-miss fault.
- R2: A request whose page number is resident is answered with its frame, rsp_fault 0 and rsp_cause 0, with rsp_valid high for one cycle exactly 2 cycles after acceptance and no memory read.
- R3: On a miss, the entry's virtual address is 0xFF800000 + VPN*8: nine leading ones, then the VPN, then three zeros. The page holding it is therefore {9'h1FF, VPN[19:9]}.
- R4: When that table page is resident with frame T, one memory read is issued at address {T, VPN[8:0], 3'b000}. mem_req and mem_addr stay stable until mem_ack, and mem_req drops after the ack.
- R5: Bit 0 of the 64-bit entry is its valid flag and bits [31:12] are the frame. A valid entry returns that frame and is written into the buffer, so a repeat request hits with no memory read.
- R6: When the table page is not resident, the response has rsp_fault 1 and rsp_cause 1, is given 3 cycles after acceptance, and issues no memory read.
- R7: An entry with bit 0 clear gives rsp_fault 1 and rsp_cause 2 and is not written into the buffer, so a repeat request reads memory again.
- R8: A single resident table page serves misses for all 512 page numbers that share VPN[19:9].
- R9: The buffer has 8 slots. A write of a non-resident page number goes to the round-robin slot and advances the pointer; a write of a resident page number overwrites in place and leaves the pointer alone.
- R10: A software insert in the same cycle as a refill is written first. The refill follows, and both mappings end up resident.
- R11: Only one request is in flight: req_ready is 0 from acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vpn | input | 20 | Requested virtual page number |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pfn | output | 20 | Resolved frame number |
| rsp_fault | output | 1 | Request could not be resolved |
| rsp_cause | output | 2 | 0 none, 1 table page unmapped, 2 entry invalid |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 32 | Physical byte address of the entry |
| mem_ack | input | 1 | Read data valid, ends the read |
| mem_rdata | input | 64 | Entry read data |
| ins_valid | input | 1 | Software mapping insert |
| ins_vpn | input | 20 | Inserted virtual page number |
| ins_pfn | input | 20 | Inserted frame number |

## Verification
The assertions check handshake behaviour on every cycle. They cover the read request holding steady until its ack, the entry address keeping 8-byte alignment, the one-cycle response strobe, agreement between fault flag and cause, and the block staying busy while a request is open. Whether a frame is correct, which slot round-robin replacement evicts, how long one table page mapping stays useful, and whether refill and insert both land after a collision can only be seen from the bench's scenarios. These include a full sweep of the 512 page numbers behind one table page.

// File: rtl/vlpt_walker.sv
module vlpt_walker #(
  parameter int VA_W      = 32,
  parameter int PAGE_W    = 12,
  parameter int PFN_W     = 20,
  parameter int PTE_SHIFT = 3,
  parameter int TLB_N     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-PAGE_W-1:0]  req_vpn,
  output logic                    rsp_valid,
  output logic [PFN_W-1:0]        rsp_pfn,
  output logic                    rsp_fault,
  output logic [1:0]              rsp_cause,
  output logic                    mem_req,
  output logic [PFN_W+PAGE_W-1:0] mem_addr,
  input  logic                    mem_ack,
  input  logic [63:0]             mem_rdata,
  input  logic                    ins_valid,
  input  logic [VA_W-PAGE_W-1:0]  ins_vpn,
  input  logic [PFN_W-1:0]        ins_pfn
);
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int TBL_HI = VA_W - VPN_W - PTE_SHIFT;
  localparam int IDX_W  = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam logic [1:0] CAUSE_NEST = 2'd1;
  localparam logic [1:0] CAUSE_PTE  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_NEST, S_MEM, S_REFILL, S_RESP, S_FAULT
  } st_t;

  st_t                st;
  logic [VPN_W-1:0]   cur_vpn;
  logic [PFN_W-1:0]   pfn_q;
  logic [PFN_W-1:0]   tbl_pfn_q;
  logic [1:0]         cause_q;

  logic [TLB_N-1:0]   t_valid;
  logic [VPN_W-1:0]   t_vpn [TLB_N];
  logic [PFN_W-1:0]   t_pfn [TLB_N];
  logic [IDX_W-1:0]   rr;

  logic [VA_W-1:0]    entry_va;
  logic [VPN_W-1:0]   tbl_vpn;
  logic [VPN_W-1:0]   key;
  logic               hit;
  logic [PFN_W-1:0]   hit_pfn;

  logic               wr_en, wr_hit;
  logic [VPN_W-1:0]   wr_vpn;
  logic [PFN_W-1:0]   wr_pfn;
  logic [IDX_W-1:0]   wr_hit_idx, wr_idx;

  assign entry_va = {{TBL_HI{1'b1}}, cur_vpn, {PTE_SHIFT{1'b0}}};
  assign tbl_vpn  = entry_va[VA_W-1:PAGE_W];
  assign key      = (st == S_NEST) ? tbl_vpn : cur_vpn;

  always_comb begin
    hit     = 1'b0;
    hit_pfn = '0;
    for (int i = 0; i < TLB_N; i++)
      if (t_valid[i] && t_vpn[i] == key) begin
        hit     = 1'b1;
        hit_pfn = t_pfn[i];
      end
  end

  assign wr_en  = ins_valid || (st == S_REFILL);
  assign wr_vpn = ins_valid ? ins_vpn : cur_vpn;
  assign wr_pfn = ins_valid ? ins_pfn : pfn_q;

  always_comb begin
    wr_hit     = 1'b0;
    wr_hit_idx = '0;
    for (int i = 0; i < TLB_N; i++)
      if (t_valid[i] && t_vpn[i] == wr_vpn) begin
        wr_hit     = 1'b1;
        wr_hit_idx = IDX_W'(i);
      end
  end

  assign wr_idx = wr_hit ? wr_hit_idx : rr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_valid <= '0;
      rr      <= '0;
    end else if (wr_en) begin
      t_valid[wr_idx] <= 1'b1;
      if (!wr_hit)
        rr <= (rr == IDX_W'(TLB_N - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      t_vpn[wr_idx] <= wr_vpn;
      t_pfn[wr_idx] <= wr_pfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_vpn   <= '0;
      pfn_q     <= '0;
      tbl_pfn_q <= '0;
      cause_q   <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (req_valid) begin
            cur_vpn <= req_vpn;
            st      <= S_LOOKUP;
          end
        S_LOOKUP:
          if (hit) begin
            pfn_q <= hit_pfn;
            st    <= S_RESP;
          end else begin
            st <= S_NEST;
          end
        S_NEST:
          if (hit) begin
            tbl_pfn_q <= hit_pfn;
            st        <= S_MEM;
          end else begin
            cause_q <= CAUSE_NEST;
            st      <= S_FAULT;
          end
        S_MEM:
          if (mem_ack) begin
            pfn_q <= mem_rdata[PAGE_W +: PFN_W];
            if (mem_rdata[0]) begin
              st <= S_REFILL;
            end else begin
              cause_q <= CAUSE_PTE;
              st      <= S_FAULT;
            end
          end
        S_REFILL:
          if (!ins_valid) st <= S_RESP;
        default:
          st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP) || (st == S_FAULT);
  assign rsp_fault = (st == S_FAULT);
  assign rsp_cause = (st == S_FAULT) ? cause_q : 2'd0;
  assign rsp_pfn   = pfn_q;
  assign mem_req   = (st == S_MEM);
  assign mem_addr  = {tbl_pfn_q, entry_va[PAGE_W-1:0]};
endmodule

module vlpt_walker_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_W    = 12,
  parameter int PFN_W     = 20,
  parameter int PTE_SHIFT = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    rsp_valid,
  input logic                    rsp_fault,
  input logic [1:0]              rsp_cause,
  input logic                    mem_req,
  input logic [PFN_W+PAGE_W-1:0] mem_addr,
  input logic                    mem_ack
);
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_mem_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  p_mem_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[PTE_SHIFT-1:0] == '0);

  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ok_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == 2'd0);

  p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && (rsp_cause == 2'd1 || rsp_cause == 2'd2));

  p_busy_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_busy_acc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !rsp_valid);
endmodule

bind vlpt_walker vlpt_walker_chk #(
  .VA_W(VA_W), .PAGE_W(PAGE_W), .PFN_W(PFN_W), .PTE_SHIFT(PTE_SHIFT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/vlpt_walker_tb_top.sv
`timescale 1ns/1ps
module vlpt_walker_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        rsp_valid;
  logic [19:0] rsp_pfn;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 0;
  logic [63:0] mem_rdata = '0;
  logic        ins_valid = 0;
  logic [19:0] ins_vpn = '0;
  logic [19:0] ins_pfn = '0;

  int checks = 0, fails = 0;
  int mem_reads = 0;
  int dly = 0;
  logic [31:0] last_addr = '0;
  logic [10:0] cur_hi = '0;
  bit          all_bad = 0;
  bit          sweep_bad = 0;

  always #2.5 clk = ~clk;

  vlpt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .rsp_valid(rsp_valid), .rsp_pfn(rsp_pfn),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn)
  );

  function automatic logic [19:0] pfn_of(logic [19:0] v);
    return 20'(v * 20'd7 + 20'd3);
  endfunction
  function automatic logic [19:0] tvpn(logic [19:0] v);
    return {9'h1FF, v[19:9]};
  endfunction
  function automatic logic [19:0] tframe(logic [10:0] hi);
    return {9'h040, hi};
  endfunction
  function automatic bit pte_ok(logic [19:0] v);
    if (all_bad) return 0;
    if (sweep_bad && (v % 11) == 3) return 0;
    return 1;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (dly == 0) begin
        logic [19:0] v;
        v = {cur_hi, mem_addr[11:3]};
        mem_rdata = {32'h0, pfn_of(v), 11'h0, pte_ok(v)};
        last_addr = mem_addr;
        mem_reads++;
        mem_ack = 1;
        dly = $urandom % 4;
      end else dly--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
  endtask

  task automatic do_ins(input logic [19:0] v, input logic [19:0] p);
    @(negedge clk); #1;
    ins_valid = 1; ins_vpn = v; ins_pfn = p;
    @(negedge clk); #1;
    ins_valid = 0;
  endtask

  task automatic do_req(input logic [19:0] v, input bit collide,
                        input logic [19:0] cv, input logic [19:0] cp,
                        output logic [19:0] pfn, output bit flt,
                        output logic [1:0] cause, output int cyc, output int reads);
    int m0, cc;
    bool_busy: begin end
    cc = 0;
    cur_hi = v[19:9];
    @(negedge clk); #1;
    chk(req_ready == 1, "R11 ready before request", req_ready, 1);
    req_valid = 1; req_vpn = v;
    m0 = mem_reads;
    cyc = 0;
    do begin
      @(negedge clk); #1;
      if (cyc == 0) req_valid = 0;
      cyc++;
      if (cc > 0) begin cc--; if (cc == 0) ins_valid = 0; end
      if (collide && mem_ack && cc == 0) begin
        ins_valid = 1; ins_vpn = cv; ins_pfn = cp; cc = 2;
      end
      if (req_ready) chk(0, "R11 ready while busy", 1, 0);
    end while (!rsp_valid && cyc < 200);
    while (cc > 0) begin
      @(negedge clk); #1; cc--; if (cc == 0) ins_valid = 0;
    end
    pfn = rsp_pfn; flt = rsp_fault; cause = rsp_cause;
    @(negedge clk); #1;
    chk(rsp_valid == 0, "R2 response is one cycle", rsp_valid, 0);
    reads = mem_reads - m0;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] pfn, v;
    logic [1:0] cause;
    bit flt;
    int cyc, reads;

    do_reset();
    // R1
    chk(req_ready == 1, "R1 reset ready", req_ready, 1);
    chk(rsp_valid == 0, "R1 reset rsp_valid", rsp_valid, 0);
    chk(mem_req == 0, "R1 reset mem_req", mem_req, 0);
    do_req(20'h12345, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(flt == 1 && cause == 1, "R1 empty buffer faults", {flt, cause}, 3'b101);
    // R6
    chk(cyc == 3, "R6 nested fault latency", cyc, 3);
    chk(reads == 0, "R6 no memory read", reads, 0);

    // R2
    do_ins(20'h00ABC, 20'h77777);
    do_req(20'h00ABC, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(pfn == 20'h77777 && !flt && cause == 0, "R2 hit frame", {flt, cause, pfn}, 20'h77777);
    chk(cyc == 2, "R2 hit latency", cyc, 2);
    chk(reads == 0, "R2 no memory read on hit", reads, 0);

    // R3 R4 R5
    v = 20'h23456;
    do_ins(tvpn(v), tframe(v[19:9]));
    do_req(v, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(!flt && pfn == pfn_of(v), "R5 walked frame", pfn, pfn_of(v));
    chk(reads == 1, "R4 one read", reads, 1);
    chk(last_addr == {tframe(v[19:9]), v[8:0], 3'b000}, "R3 entry address",
        last_addr, {tframe(v[19:9]), v[8:0], 3'b000});
    do_req(v, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(reads == 0 && cyc == 2 && pfn == pfn_of(v), "R5 refilled hit", reads, 0);

    // R7
    all_bad = 1;
    do_req(20'h23457, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(flt && cause == 2, "R7 invalid entry cause", cause, 2);
    chk(reads == 1, "R7 read made", reads, 1);
    do_req(20'h23457, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(flt && cause == 2 && reads == 1, "R7 not refilled", reads, 1);
    all_bad = 0;

    // R8 R9: one table page feeds 8 walks, then round robin evicts it
    do_reset();
    do_ins(tvpn(20'h5A000), tframe(11'h2D0));
    for (int i = 0; i < 8; i++) begin
      v = 20'h5A000 + 20'(i * 37);
      do_req(v, 0, 0, 0, pfn, flt, cause, cyc, reads);
      chk(!flt && pfn == pfn_of(v) && reads == 1, "R8 walk via one table page", pfn, pfn_of(v));
    end
    do_req(20'h5A1FF, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(flt && cause == 1 && reads == 0, "R9 table page evicted by round robin", cause, 1);

    // R8 sweep of all 512 page numbers under one table page
    do_reset();
    sweep_bad = 1;
    for (int i = 0; i < 512; i++) begin
      v = {11'h3C5, 9'(i)};
      do_ins(tvpn(v), tframe(11'h3C5));
      do_req(v, 0, 0, 0, pfn, flt, cause, cyc, reads);
      if (pte_ok(v))
        chk(!flt && pfn == pfn_of(v) && reads == 1, "R8 sweep frame", pfn, pfn_of(v));
      else
        chk(flt && cause == 2, "R8 sweep invalid entry", cause, 2);
      chk(last_addr == {tframe(11'h3C5), 9'(i), 3'b000}, "R3 sweep address",
          last_addr, {tframe(11'h3C5), 9'(i), 3'b000});
    end
    sweep_bad = 0;

    // R9 round robin and in-place overwrite
    do_reset();
    for (int i = 0; i < 9; i++) do_ins(20'h00100 + 20'(i), 20'h00200 + 20'(i));
    do_req(20'h00100, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(flt && cause == 1, "R9 oldest slot replaced", cause, 1);
    for (int i = 1; i < 9; i++) begin
      do_req(20'h00100 + 20'(i), 0, 0, 0, pfn, flt, cause, cyc, reads);
      chk(!flt && pfn == 20'h00200 + 20'(i), "R9 resident after wrap", pfn, 20'h00200 + 20'(i));
    end
    do_ins(20'h00101, 20'h00999);
    do_req(20'h00101, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(!flt && pfn == 20'h00999, "R9 overwrite in place", pfn, 20'h00999);
    do_req(20'h00102, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(!flt && pfn == 20'h00202, "R9 overwrite keeps pointer", pfn, 20'h00202);

    // R10 insert colliding with refill
    do_reset();
    v = 20'h30000;
    do_ins(tvpn(v), tframe(v[19:9]));
    do_req(v, 1, 20'h05555, 20'h0AAAA, pfn, flt, cause, cyc, reads);
    chk(!flt && pfn == pfn_of(v), "R10 walk completes", pfn, pfn_of(v));
    do_req(20'h05555, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(!flt && pfn == 20'h0AAAA && reads == 0, "R10 software mapping resident", pfn, 20'h0AAAA);
    do_req(v, 0, 0, 0, pfn, flt, cause, cyc, reads);
    chk(!flt && pfn == pfn_of(v) && reads == 0, "R10 refill mapping resident", pfn, pfn_of(v));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule